// File: doc/BRIEF.md
# Framed Configuration Record Parser

This block sits between a host link and an acquisition engine. It takes a stream of 16-bit configuration words and, inside a frame delimited by a 32-bit opening marker and a 32-bit closing marker, decodes tagged records. Each record starts with a header word that carries a variable index and a payload length in words. The payload is written into staging registers. The staging contents become visible on the configuration outputs only when the closing marker arrives. At that point a one-cycle `done_o` pulse is raised. A malformed frame raises a one-cycle `err_o` pulse, is dropped entirely and leaves the outputs untouched.

The word input is a valid/ready interface. A word transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` goes high one cycle after reset is released and then stays high: the parser never applies back-pressure. The producer may leave `in_valid` low for any number of cycles between words, and the gaps have no effect on decoding. The scalar settings are flat output ports. The trigger table is read through a combinational word-indexed read port, so the acquisition engine can fetch entries on demand.

Top module: `tlv_cfg_parser`

## Requirements
- R1: While no frame is open, every word is discarded. A single 0xF5A5 followed by any other word does not open a frame.
- R2: Two consecutive accepted words of 0xF5A5 open a frame. When a frame opens, the staging copy is reloaded from the committed outputs.
- R3: Inside a frame, a header word has the index in bits 15:8 and the payload length in words in bits 7:0. The known records are:
  - index 0: mode, 1 word
  - index 1: divider, 2 words
  - index 3: sample count, 2 words
  - index 5: trigger position, 2 words
  - index 7: global trigger word, 1 word
  - index 8: channel enable, 1 word
  - index 64: trigger table, 10×NSTAGE words (160 by default)
- R4: A two-word value arrives low word first. The first word sets bits 15:0 and the second sets bits 31:16.
- R5: The payload of the trigger table record is stored at word positions 0 to 10×NSTAGE−1, in arrival order. `tbl_rdata` returns the committed word at position `tbl_raddr`. Positions are laid out as follows:
  - eight arrays of NSTAGE words each, at positions a×NSTAGE+s
  - a two-word count per stage, at positions 8×NSTAGE+2s (low word) and 8×NSTAGE+2s+1 (high word)
- R6: A header with an unknown index produces a one-cycle `err_o` pulse one cycle after it is accepted. The parser then returns to hunting and commits nothing.
- R7: A header with a known index but a wrong length is treated the same way as in R6.
- R8: The closing marker is 0xFA5A followed by 0xFA5A, read where a header is expected. After its second word is accepted, the outputs and `done_o` change on the same edge, and `done_o` is high for exactly one cycle. The outputs change at no other time.
- R9: A 0xFA5A that is not followed by 0xFA5A produces an `err_o` pulse and no commit.
- R10: A record that is absent from a successful frame keeps its previously committed value. A failed frame leaves every output unchanged.
- R11: `in_ready` is high from the first cycle after reset. Gaps in `in_valid` do not change the decoded result.
- R12: After reset, every configuration output and every table word is zero, and `done_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word valid |
| in_data | input | 16 | Configuration word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| cfg_mode_o | output | 16 | Committed mode word |
| cfg_div_o | output | 32 | Committed clock divider |
| cfg_count_o | output | 32 | Committed sample count |
| cfg_tpos_o | output | 32 | Committed trigger position |
| cfg_glb_o | output | 16 | Committed global trigger word |
| cfg_chen_o | output | 16 | Committed channel enable mask |
| tbl_raddr | input | TAW | Trigger table word position |
| tbl_rdata | output | 16 | Committed trigger table word |
| done_o | output | 1 | One-cycle pulse on a committed frame |
| err_o | output | 1 | One-cycle pulse on a rejected frame |

## Verification
The bench targets the following corner cases and the failure each one would reveal:
- **Lone 0xF5A5 in leading garbage.** A parser that opens a frame too early would misread the next words as headers and raise a spurious error.
- **Closing marker sent after a rejected header.** A parser that did not return to hunting would treat the marker as a frame end and report completion.
- **Broken closing marker.** A parser that committed on a single 0xFA5A would corrupt the outputs.
- **Frame carrying only the divider, with gaps in valid.** This shows whether the other fields keep their committed values.
- **Word-order checks.** The divider and trigger-table readbacks would expose swapped halves or a shifted table layout.

// File: rtl/tlv_cfg_pkg.sv
package tlv_cfg_pkg;

  typedef enum logic [2:0] {
    ST_HUNT0,
    ST_HUNT1,
    ST_HDR,
    ST_BODY,
    ST_END1
  } pstate_t;

  typedef enum logic [2:0] {
    RID_MODE,
    RID_DIV,
    RID_CNT,
    RID_TPOS,
    RID_GLB,
    RID_CHEN,
    RID_TBL,
    RID_NONE
  } rec_t;

  localparam logic [15:0] SYNC_HALF = 16'hF5A5;
  localparam logic [15:0] TERM_HALF = 16'hFA5A;

  localparam logic [7:0] IX_MODE = 8'd0;
  localparam logic [7:0] IX_DIV  = 8'd1;
  localparam logic [7:0] IX_CNT  = 8'd3;
  localparam logic [7:0] IX_TPOS = 8'd5;
  localparam logic [7:0] IX_GLB  = 8'd7;
  localparam logic [7:0] IX_CHEN = 8'd8;
  localparam logic [7:0] IX_TBL  = 8'd64;

endpackage

// File: rtl/tlv_hdr_decode.sv
module tlv_hdr_decode
  import tlv_cfg_pkg::*;
#(
  parameter int TBL_WORDS = 160
) (
  input  logic [15:0] hdr,
  output rec_t        rid,
  output logic [7:0]  plen,
  output logic        hdr_ok
);
  localparam logic [7:0] TBL_LEN = 8'(TBL_WORDS);

  logic [7:0] idx;
  logic [7:0] len;

  assign idx = hdr[15:8];
  assign len = hdr[7:0];

  always_comb begin
    rid  = RID_NONE;
    plen = 8'd0;
    case (idx)
      IX_MODE: begin rid = RID_MODE; plen = 8'd1;    end
      IX_DIV:  begin rid = RID_DIV;  plen = 8'd2;    end
      IX_CNT:  begin rid = RID_CNT;  plen = 8'd2;    end
      IX_TPOS: begin rid = RID_TPOS; plen = 8'd2;    end
      IX_GLB:  begin rid = RID_GLB;  plen = 8'd1;    end
      IX_CHEN: begin rid = RID_CHEN; plen = 8'd1;    end
      IX_TBL:  begin rid = RID_TBL;  plen = TBL_LEN; end
      default: begin rid = RID_NONE; plen = 8'd0;    end
    endcase
  end

  assign hdr_ok = (rid != RID_NONE) && (len == plen);

endmodule

// File: rtl/tlv_scalar_bank.sv
module tlv_scalar_bank
  import tlv_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_stage,
  input  logic        we,
  input  rec_t        rid,
  input  logic        hi_half,
  input  logic [15:0] wdata,
  input  logic        commit,
  output logic [15:0] mode_o,
  output logic [31:0] div_o,
  output logic [31:0] count_o,
  output logic [31:0] tpos_o,
  output logic [15:0] glb_o,
  output logic [15:0] chen_o
);
  logic [15:0] s_mode, s_glb, s_chen;
  logic [31:0] s_div, s_count, s_tpos;

  function automatic logic [31:0] put_half(input logic [31:0] cur,
                                           input logic        hi,
                                           input logic [15:0] w);
    return hi ? {w, cur[15:0]} : {cur[31:16], w};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_mode <= '0; s_div <= '0; s_count <= '0;
      s_tpos <= '0; s_glb <= '0; s_chen  <= '0;
    end else if (load_stage) begin
      s_mode <= mode_o; s_div <= div_o; s_count <= count_o;
      s_tpos <= tpos_o; s_glb <= glb_o; s_chen  <= chen_o;
    end else if (we) begin
      case (rid)
        RID_MODE: s_mode  <= wdata;
        RID_DIV:  s_div   <= put_half(s_div, hi_half, wdata);
        RID_CNT:  s_count <= put_half(s_count, hi_half, wdata);
        RID_TPOS: s_tpos  <= put_half(s_tpos, hi_half, wdata);
        RID_GLB:  s_glb   <= wdata;
        RID_CHEN: s_chen  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_o <= '0; div_o <= '0; count_o <= '0;
      tpos_o <= '0; glb_o <= '0; chen_o  <= '0;
    end else if (commit) begin
      mode_o <= s_mode; div_o <= s_div; count_o <= s_count;
      tpos_o <= s_tpos; glb_o <= s_glb; chen_o  <= s_chen;
    end
  end

  // R8: committed settings move only on the edge that follows a commit
  assert_out_commit_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mode_o) || !$stable(div_o) || !$stable(count_o) ||
     !$stable(tpos_o) || !$stable(glb_o) || !$stable(chen_o)) |-> $past(commit));

  // R2: reload and commit are exclusive
  assert_load_commit_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_stage && commit));

endmodule

// File: rtl/tlv_trig_table.sv
module tlv_trig_table #(
  parameter int TBL_WORDS = 160,
  parameter int TAW       = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_stage,
  input  logic           we,
  input  logic [TAW-1:0] waddr,
  input  logic [15:0]    wdata,
  input  logic           commit,
  input  logic [TAW-1:0] raddr,
  output logic [15:0]    rdata
);
  logic [15:0] stg [TBL_WORDS];
  logic [15:0] act [TBL_WORDS];

  for (genvar i = 0; i < TBL_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[i] <= '0;
        act[i] <= '0;
      end else begin
        if (load_stage)
          stg[i] <= act[i];
        else if (we && (int'(waddr) == i))
          stg[i] <= wdata;
        if (commit)
          act[i] <= stg[i];
      end
    end
  end

  assign rdata = (int'(raddr) < TBL_WORDS) ? act[raddr] : 16'h0000;

  // R5: table writes stay within the record
  assert_waddr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(waddr) < TBL_WORDS));

endmodule

// File: rtl/tlv_cfg_parser.sv
module tlv_cfg_parser
  import tlv_cfg_pkg::*;
#(
  parameter int NSTAGE = 16,
  parameter int TAW    = $clog2(10 * NSTAGE)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [15:0]    in_data,
  output logic           in_ready,
  output logic [15:0]    cfg_mode_o,
  output logic [31:0]    cfg_div_o,
  output logic [31:0]    cfg_count_o,
  output logic [31:0]    cfg_tpos_o,
  output logic [15:0]    cfg_glb_o,
  output logic [15:0]    cfg_chen_o,
  input  logic [TAW-1:0] tbl_raddr,
  output logic [15:0]    tbl_rdata,
  output logic           done_o,
  output logic           err_o
);
  localparam int TBL_WORDS = 10 * NSTAGE;

  pstate_t    st;
  rec_t       rid_q, rid_d;
  logic [7:0] len_q, plen_d;
  logic [7:0] cnt;
  logic       hdr_ok;
  logic       acc, load_stage, body_we, commit, bad;
  logic       is_sync, is_term;

  tlv_hdr_decode #(.TBL_WORDS(TBL_WORDS)) u_dec (
    .hdr(in_data), .rid(rid_d), .plen(plen_d), .hdr_ok(hdr_ok)
  );

  assign acc     = in_valid && in_ready;
  assign is_sync = (in_data == SYNC_HALF);
  assign is_term = (in_data == TERM_HALF);

  assign load_stage = acc && (st == ST_HUNT1) && is_sync;
  assign body_we    = acc && (st == ST_BODY);
  assign commit     = acc && (st == ST_END1) && is_term;
  assign bad        = acc && (((st == ST_HDR) && !is_term && !hdr_ok) ||
                              ((st == ST_END1) && !is_term));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_HUNT0;
      rid_q    <= RID_NONE;
      len_q    <= '0;
      cnt      <= '0;
      in_ready <= 1'b0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      done_o   <= commit;
      err_o    <= bad;
      if (acc) begin
        case (st)
          ST_HUNT0: if (is_sync) st <= ST_HUNT1;
          ST_HUNT1: st <= is_sync ? ST_HDR : ST_HUNT0;
          ST_HDR: begin
            if (is_term) begin
              st <= ST_END1;
            end else if (hdr_ok) begin
              rid_q <= rid_d;
              len_q <= plen_d;
              cnt   <= '0;
              st    <= ST_BODY;
            end else begin
              st <= ST_HUNT0;
            end
          end
          ST_BODY: begin
            cnt <= cnt + 8'd1;
            if (cnt == len_q - 8'd1) st <= ST_HDR;
          end
          ST_END1: st <= ST_HUNT0;
          default: st <= ST_HUNT0;
        endcase
      end
    end
  end

  tlv_scalar_bank u_scal (
    .clk(clk), .rst_n(rst_n), .load_stage(load_stage),
    .we(body_we && (rid_q != RID_TBL)), .rid(rid_q), .hi_half(cnt[0]),
    .wdata(in_data), .commit(commit),
    .mode_o(cfg_mode_o), .div_o(cfg_div_o), .count_o(cfg_count_o),
    .tpos_o(cfg_tpos_o), .glb_o(cfg_glb_o), .chen_o(cfg_chen_o)
  );

  tlv_trig_table #(.TBL_WORDS(TBL_WORDS), .TAW(TAW)) u_tbl (
    .clk(clk), .rst_n(rst_n), .load_stage(load_stage),
    .we(body_we && (rid_q == RID_TBL)), .waddr(cnt[TAW-1:0]),
    .wdata(in_data), .commit(commit), .raddr(tbl_raddr), .rdata(tbl_rdata)
  );

  // R8: done lasts a single cycle
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6: an error never coincides with a commit
  assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  // R7: an error follows an accepted word
  assert_err_after_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(acc));

  // R3: payload position stays below the record length
  assert_body_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BODY) |-> (cnt < len_q));

  // R11: ready never drops once raised
  assert_ready_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_ready) |-> in_ready);

endmodule

// File: tb/tlv_cfg_parser_tb.sv
module tlv_cfg_parser_tb;
  localparam int NSTAGE = 16;
  localparam int TAW    = $clog2(10 * NSTAGE);

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [15:0]    in_data = '0;
  logic           in_ready;
  logic [15:0]    cfg_mode_o, cfg_glb_o, cfg_chen_o;
  logic [31:0]    cfg_div_o, cfg_count_o, cfg_tpos_o;
  logic [TAW-1:0] tbl_raddr = '0;
  logic [15:0]    tbl_rdata;
  logic           done_o, err_o;

  int checks = 0;
  int fails  = 0;
  int expq[$];   // 1 = done expected, 2 = err expected

  always #10 clk = ~clk;

  tlv_cfg_parser #(.NSTAGE(NSTAGE)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .cfg_mode_o(cfg_mode_o), .cfg_div_o(cfg_div_o),
    .cfg_count_o(cfg_count_o), .cfg_tpos_o(cfg_tpos_o), .cfg_glb_o(cfg_glb_o),
    .cfg_chen_o(cfg_chen_o), .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [15:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic sync();
    put(16'hF5A5);
    put(16'hF5A5);
  endtask

  task automatic tbl_chk(input string req, input int addr, input logic [15:0] exp);
    @(negedge clk);
    tbl_raddr = TAW'(addr);
    #1 check(req, {16'h0, tbl_rdata}, {16'h0, exp});
  endtask

  // monitor: every pulse must match the next expected event
  always @(negedge clk) begin
    if (rst_n && (done_o || err_o)) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R8/R6 unexpected event actual done=%0b err=%0b expected none", done_o, err_o);
      end else begin
        int e;
        e = expq.pop_front();
        if ((e == 1 && !(done_o && !err_o)) || (e == 2 && !(err_o && !done_o))) begin
          fails++;
          $display("FAIL R8/R6 event actual done=%0b err=%0b expected kind=%0d", done_o, err_o, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state, R11 ready
    check("R12 mode", {16'h0, cfg_mode_o}, 32'h0);
    check("R12 div", cfg_div_o, 32'h0);
    check("R12 flags", {30'h0, done_o, err_o}, 32'h0);
    check("R11 ready", {31'h0, in_ready}, 32'h1);
    tbl_chk("R12 table", 5, 16'h0000);

    // R1: garbage including a lone sync half
    put(16'h1234); put(16'hF5A5); put(16'h0000);
    // R2, R3, R4, R5: full frame
    sync();
    put(16'h0001); put(16'h00AB);
    put(16'h0102); put(16'h0002); put(16'h0001);
    put(16'h0302); put(16'h4444); put(16'h0033);
    put(16'h0502); put(16'h0100); put(16'h0000);
    put(16'h0701); put(16'h0206);
    put(16'h0801); put(16'h00FF);
    put(16'h40A0);
    for (int i = 0; i < 10 * NSTAGE; i++) put(16'h5000 + 16'(i));
    @(negedge clk);
    check("R8 no early commit", {16'h0, cfg_mode_o}, 32'h0);
    expq.push_back(1);
    put(16'hFA5A); put(16'hFA5A);
    idle(2);
    @(negedge clk);
    check("R3 mode", {16'h0, cfg_mode_o}, 32'h00AB);
    check("R4 div", cfg_div_o, 32'h0001_0002);
    check("R4 count", cfg_count_o, 32'h0033_4444);
    check("R4 tpos", cfg_tpos_o, 32'h0000_0100);
    check("R3 glb", {16'h0, cfg_glb_o}, 32'h0206);
    check("R3 chen", {16'h0, cfg_chen_o}, 32'h00FF);
    tbl_chk("R5 mask0[0]", 0, 16'h5000);
    tbl_chk("R5 mask1[1]", 17, 16'h5011);
    tbl_chk("R5 logic1[15]", 127, 16'h507F);
    tbl_chk("R5 count0 lo", 128, 16'h5080);
    tbl_chk("R5 count0 hi", 129, 16'h5081);
    tbl_chk("R5 count15 hi", 159, 16'h509F);

    // R6: unknown index aborts; later end marker is ignored
    sync();
    put(16'h0001); put(16'h0077);
    expq.push_back(2);
    put(16'h0201);
    put(16'hFA5A); put(16'hFA5A);
    idle(2);
    @(negedge clk);
    check("R6 mode kept", {16'h0, cfg_mode_o}, 32'h00AB);

    // R7: known index with wrong length
    sync();
    expq.push_back(2);
    put(16'h0002);
    idle(2);
    @(negedge clk);
    check("R7 mode kept", {16'h0, cfg_mode_o}, 32'h00AB);

    // R7: table record with wrong length
    sync();
    expq.push_back(2);
    put(16'h409F);
    idle(2);

    // R9: broken end marker
    sync();
    put(16'h0001); put(16'h0055);
    put(16'hFA5A);
    expq.push_back(2);
    put(16'h1111);
    idle(2);
    @(negedge clk);
    check("R9 mode kept", {16'h0, cfg_mode_o}, 32'h00AB);

    // R10, R11: divider only, with gaps in valid
    put(16'hF5A5); idle(3); put(16'hF5A5);
    put(16'h0102); idle(2); put(16'hBEEF); idle(4); put(16'hCAFE);
    put(16'hFA5A); idle(1);
    expq.push_back(1);
    put(16'hFA5A);
    idle(2);
    @(negedge clk);
    check("R11 div with gaps", cfg_div_o, 32'hCAFE_BEEF);
    check("R10 mode kept", {16'h0, cfg_mode_o}, 32'h00AB);
    check("R10 count kept", cfg_count_o, 32'h0033_4444);
    tbl_chk("R10 table kept", 17, 16'h5011);

    idle(3);
    check("R8 all events seen", expq.size(), 32'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule